// File: doc/BRIEF.md
# Variable-Page Data Translation Buffer

This block is a fully associative translation buffer for data addresses. Each slot holds a virtual page number tag, a physical page number, a page-size code, an address-space number, a global flag and a protection field. A lookup is purely combinational: the virtual address and the current address-space number go in, and the hit flag, physical address and protection bits come out in the same cycle. The low 13 address bits are the offset inside the 8 KB base page and pass through unchanged.

A slot can cover a naturally aligned block of 1, 8, 64 or 512 base pages. The size code tells the compare to ignore the low 0, 3, 6 or 9 virtual page number bits. Those same low bits of the physical page number are then taken from the virtual address. The fill port writes the slot named by a round-robin pointer, and the pointer moves on after every fill. Two invalidate commands clear either every slot or only the non-global slots. Page-table walking and fault handling are left to the surrounding logic.

Top module: `dtlb_var`

## Requirements
- R1: After reset every slot is invalid, so no lookup hits, and the round-robin pointer selects slot 0.
- R2: A lookup hits when a valid slot's tag equals the virtual page number (`lk_va` above bit 12). On a hit, `lk_pa` is the slot's physical page number above bit 12, followed by `lk_va[12:0]` unchanged.
- R3: `fill_size` is coded 0, 1, 2 and 3 for 1, 8, 64 and 512 pages. The code masks the low 0, 3, 6 or 9 virtual page number bits out of the compare. In `lk_pa` those same low page bits are taken from `lk_va` and not from the stored physical page number.
- R4: A slot whose global flag (`fill_glb` = 1) is clear hits only when its stored address-space number equals `lk_asn`. A global slot ignores `lk_asn`.
- R5: On a hit, `lk_prot` returns the protection field written with the winning slot.
- R6: A fill writes the slot at the pointer and makes it valid. The pointer advances by one only on a fill and wraps from the last slot to slot 0, so fill number ENTRIES+1 replaces the first slot that was filled.
- R7: `inv_all` makes every slot invalid from the next cycle on.
- R8: `inv_local` makes invalid only the slots whose global flag is clear. Global slots keep hitting.
- R9: When more than one slot matches, the lowest-index slot supplies `lk_pa` and `lk_prot`, and `lk_multi` is 1. When one slot or none matches, `lk_multi` is 0.
- R10: A fill in the same cycle as an invalidate command leaves the newly filled slot valid. The invalidate still applies to every other slot.
- R11: When no slot matches, `lk_hit` and `lk_multi` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | A valid slot matched |
| lk_pa | output | PA_W | Translated physical address (meaningless on a miss) |
| lk_prot | output | PROT_W | Protection bits of the winning slot |
| lk_multi | output | 1 | More than one slot matched |
| fill_en | input | 1 | Write a new translation into the slot at the pointer |
| fill_vpn | input | VA_W-13 | Virtual page number of the new translation |
| fill_pfn | input | PA_W-13 | Physical page number of the new translation |
| fill_size | input | 2 | Page-block size code (0:1, 1:8, 2:64, 3:512 pages) |
| fill_asn | input | ASN_W | Address-space number of the new translation |
| fill_glb | input | 1 | 1 makes the new translation match every address-space number |
| fill_prot | input | PROT_W | Protection bits of the new translation |
| inv_all | input | 1 | Invalidate every slot |
| inv_local | input | 1 | Invalidate the non-global slots |

## Verification
The bench runs a small eight-slot setup and sweeps every virtual page number under several address-space numbers. It compares each lookup with a bench model that matches pages by shifting and builds physical pages arithmetically. If the size mask or the page merge were wrong, addresses at the edges of the 8-, 64- and 512-page blocks would miss, hit where they should not, or return low page bits from the wrong source. If the global flag or the address-space compare were wrong, the slots that share page 20 under different address-space numbers would resolve wrongly. The bench also covers the pointer wrap on the ninth fill, an overlap that two slots match, and invalidates alone and together with a fill. A design that got these wrong would keep the oldest slot, pick the higher slot, miss the multi-match flag, keep or drop the wrong slots, or lose the fresh fill.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

   // each size step hides three more page-number bits
   localparam int SZ_STEP  = 3;
   localparam int SZ_CODES = 4;
   localparam int SZ_SPAN  = SZ_STEP * (SZ_CODES - 1);

   typedef enum logic [1:0] {
      PG_X1   = 2'd0,
      PG_X8   = 2'd1,
      PG_X64  = 2'd2,
      PG_X512 = 2'd3
   } pg_size_e;

   // ones in the page-number bits that the size code hides from the compare
   function automatic logic [SZ_SPAN-1:0] low_mask(input pg_size_e sz);
      logic [SZ_SPAN-1:0] ones;
      ones = '1;
      return ~(ones << (SZ_STEP * int'(sz)));
   endfunction

endpackage

// File: rtl/dtlb_slot.sv
module dtlb_slot
   import dtlb_pkg::*;
#(
   parameter int VPN_W  = 30,
   parameter int PFN_W  = 31,
   parameter int ASN_W  = 8,
   parameter int PROT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              clr_all,
   input  logic              clr_local,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [PFN_W-1:0]  wr_pfn,
   input  pg_size_e          wr_size,
   input  logic [ASN_W-1:0]  wr_asn,
   input  logic              wr_glb,
   input  logic [PROT_W-1:0] wr_prot,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASN_W-1:0]  lk_asn,
   output logic              match,
   output logic [PFN_W-1:0]  ppn,
   output logic [PROT_W-1:0] prot
);

   localparam int LO = SZ_SPAN;

   logic              vld_q;
   logic [VPN_W-1:0]  vpn_q;
   logic [PFN_W-1:0]  pfn_q;
   pg_size_e          size_q;
   logic [ASN_W-1:0]  asn_q;
   logic              glb_q;
   logic [PROT_W-1:0] prot_q;
   logic [LO-1:0]     hide;
   logic              hi_eq, lo_eq, asn_ok;

   // a fill wins over any clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            vld_q <= 1'b0;
      else if (wr_en)                        vld_q <= 1'b1;
      else if (clr_all || (clr_local && !glb_q)) vld_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         vpn_q  <= wr_vpn;
         pfn_q  <= wr_pfn;
         size_q <= wr_size;
         asn_q  <= wr_asn;
         glb_q  <= wr_glb;
         prot_q <= wr_prot;
      end
   end

   always_comb begin
      hide   = low_mask(size_q);
      hi_eq  = (lk_vpn[VPN_W-1:LO] == vpn_q[VPN_W-1:LO]);
      lo_eq  = (((lk_vpn[LO-1:0] ^ vpn_q[LO-1:0]) & ~hide) == '0);
      asn_ok = glb_q || (asn_q == lk_asn);
      match  = vld_q && hi_eq && lo_eq && asn_ok;
      ppn    = {pfn_q[PFN_W-1:LO], (pfn_q[LO-1:0] & ~hide) | (lk_vpn[LO-1:0] & hide)};
      prot   = prot_q;
   end

   AST_SLOT_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld_q); // R6
   AST_SLOT_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all && !wr_en) |=> !vld_q); // R7
   AST_SLOT_KEEP_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_local && !clr_all && !wr_en && vld_q && glb_q) |=> vld_q); // R8
   AST_SLOT_DROP_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_local && !wr_en && !glb_q) |=> !vld_q); // R8

endmodule

// File: rtl/dtlb_pick.sv
module dtlb_pick #(
   parameter int N = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any,
   output logic         multi
);

   // isolate the lowest set bit; a second set bit marks an overlap
   always_comb begin
      grant = req & (~req + N'(1));
      any   = |req;
      multi = |(req & (req - N'(1)));
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R9
   AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0); // R9
   AST_MULTI_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      multi == ($countones(req) > 1)); // R9

endmodule

// File: rtl/dtlb_rr.sv
module dtlb_rr #(
   parameter int N     = 128,
   parameter int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ptr <= '0;
      else if (adv)          ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(ptr)); // R6
   AST_RR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ptr == LAST) |=> ptr == '0); // R6
   AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ptr != LAST) |=> ptr == $past(ptr) + 1'b1); // R6

endmodule

// File: rtl/dtlb_var.sv
module dtlb_var
   import dtlb_pkg::*;
#(
   parameter int ENTRIES = 128,
   parameter int VA_W    = 43,
   parameter int PA_W    = 44,
   parameter int ASN_W   = 8,
   parameter int PROT_W  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [VA_W-1:0]      lk_va,
   input  logic [ASN_W-1:0]     lk_asn,
   output logic                 lk_hit,
   output logic [PA_W-1:0]      lk_pa,
   output logic [PROT_W-1:0]    lk_prot,
   output logic                 lk_multi,
   input  logic                 fill_en,
   input  logic [VA_W-14:0]     fill_vpn,
   input  logic [PA_W-14:0]     fill_pfn,
   input  logic [1:0]           fill_size,
   input  logic [ASN_W-1:0]     fill_asn,
   input  logic                 fill_glb,
   input  logic [PROT_W-1:0]    fill_prot,
   input  logic                 inv_all,
   input  logic                 inv_local
);

   localparam int PG_OFS = 13;
   localparam int VPN_W  = VA_W - PG_OFS;
   localparam int PFN_W  = PA_W - PG_OFS;
   localparam int IDX_W  = $clog2(ENTRIES);

   if (ENTRIES < 2)      begin : g_chk_n   $error("dtlb_var: ENTRIES must be at least 2");           end
   if (VPN_W <= SZ_SPAN) begin : g_chk_va  $error("dtlb_var: VA_W too small for largest page block"); end
   if (PFN_W <= SZ_SPAN) begin : g_chk_pa  $error("dtlb_var: PA_W too small for largest page block"); end
   if (ASN_W < 1)        begin : g_chk_asn $error("dtlb_var: ASN_W must be positive");               end

   logic [IDX_W-1:0]   ptr;
   logic [ENTRIES-1:0] req, grant;
   logic [PFN_W-1:0]   ppn_a  [ENTRIES];
   logic [PROT_W-1:0]  prot_a [ENTRIES];
   logic [PFN_W-1:0]   ppn_sel;
   logic [PROT_W-1:0]  prot_sel;
   logic [VPN_W-1:0]   lk_vpn;

   assign lk_vpn = lk_va[VA_W-1:PG_OFS];

   dtlb_rr #(.N(ENTRIES), .IDX_W(IDX_W)) u_rr (
      .clk (clk), .rst_n (rst_n), .adv (fill_en), .ptr (ptr)
   );

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      dtlb_slot #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ASN_W(ASN_W), .PROT_W(PROT_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (fill_en && (ptr == IDX_W'(i))),
         .clr_all   (inv_all),
         .clr_local (inv_local),
         .wr_vpn    (fill_vpn),
         .wr_pfn    (fill_pfn),
         .wr_size   (pg_size_e'(fill_size)),
         .wr_asn    (fill_asn),
         .wr_glb    (fill_glb),
         .wr_prot   (fill_prot),
         .lk_vpn    (lk_vpn),
         .lk_asn    (lk_asn),
         .match     (req[i]),
         .ppn       (ppn_a[i]),
         .prot      (prot_a[i])
      );
   end

   dtlb_pick #(.N(ENTRIES)) u_pick (
      .clk (clk), .rst_n (rst_n), .req (req),
      .grant (grant), .any (lk_hit), .multi (lk_multi)
   );

   // one-hot and-or select of the winning slot
   always_comb begin
      ppn_sel  = '0;
      prot_sel = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         ppn_sel  |= {PFN_W{grant[i]}}  & ppn_a[i];
         prot_sel |= {PROT_W{grant[i]}} & prot_a[i];
      end
   end

   assign lk_pa   = {ppn_sel, lk_va[PG_OFS-1:0]};
   assign lk_prot = prot_sel;

   AST_EMPTY_AFTER_INV: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_all && !fill_en) |=> !lk_hit); // R7
   AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> !lk_multi); // R11
   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_pa[PG_OFS-1:0] == lk_va[PG_OFS-1:0]); // R2

endmodule

// File: tb/dtlb_var_tb.sv
module dtlb_var_tb;

   localparam int N      = 8;
   localparam int VA_W   = 24;
   localparam int PA_W   = 26;
   localparam int ASN_W  = 8;
   localparam int PROT_W = 4;
   localparam int VPN_W  = VA_W - 13;
   localparam int PFN_W  = PA_W - 13;
   localparam int NPAGES = 1 << VPN_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [VA_W-1:0]   lk_va = '0;
   logic [ASN_W-1:0]  lk_asn = '0;
   logic              lk_hit, lk_multi;
   logic [PA_W-1:0]   lk_pa;
   logic [PROT_W-1:0] lk_prot;
   logic              fill_en = 1'b0;
   logic [VPN_W-1:0]  fill_vpn = '0;
   logic [PFN_W-1:0]  fill_pfn = '0;
   logic [1:0]        fill_size = '0;
   logic [ASN_W-1:0]  fill_asn = '0;
   logic              fill_glb = 1'b0;
   logic [PROT_W-1:0] fill_prot = '0;
   logic              inv_all = 1'b0;
   logic              inv_local = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model of the slots
   int m_v [N], m_vpn [N], m_pfn [N], m_sz [N], m_asn [N], m_g [N], m_prot [N];
   int m_ptr = 0;

   always #10 clk = ~clk;

   dtlb_var #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .ASN_W(ASN_W), .PROT_W(PROT_W)) u_dut (
      .clk (clk), .rst_n (rst_n),
      .lk_va (lk_va), .lk_asn (lk_asn), .lk_hit (lk_hit), .lk_pa (lk_pa),
      .lk_prot (lk_prot), .lk_multi (lk_multi),
      .fill_en (fill_en), .fill_vpn (fill_vpn), .fill_pfn (fill_pfn),
      .fill_size (fill_size), .fill_asn (fill_asn), .fill_glb (fill_glb),
      .fill_prot (fill_prot), .inv_all (inv_all), .inv_local (inv_local)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one clocked command; invalidates act first, then the fill
   task automatic op(input bit f, input bit ia, input bit il, input int vpn, input int pfn,
                     input int sz, input int asn, input int g, input int prot);
      @(negedge clk);
      fill_en = f; inv_all = ia; inv_local = il;
      fill_vpn = VPN_W'(vpn); fill_pfn = PFN_W'(pfn); fill_size = 2'(sz);
      fill_asn = ASN_W'(asn); fill_glb = g[0]; fill_prot = PROT_W'(prot);
      @(negedge clk);
      fill_en = 0; inv_all = 0; inv_local = 0;
      for (int i = 0; i < N; i++) begin
         if (ia) m_v[i] = 0;
         if (il && m_g[i] == 0) m_v[i] = 0;
      end
      if (f) begin
         m_v[m_ptr] = 1; m_vpn[m_ptr] = vpn; m_pfn[m_ptr] = pfn; m_sz[m_ptr] = sz;
         m_asn[m_ptr] = asn; m_g[m_ptr] = g; m_prot[m_ptr] = prot;
         m_ptr = (m_ptr + 1) % N;
      end
   endtask

   // block-aligned match by shifting; physical page rebuilt by division
   task automatic lookup(input string req, input int vpn, input int asn);
      int off, sh, blk, cnt, first, exp_pa, exp_prot;
      off = (vpn * 97 + asn * 11) % 8192;
      cnt = 0; first = -1; exp_pa = 0; exp_prot = 0;
      for (int i = 0; i < N; i++) begin
         sh = 3 * m_sz[i];
         if (m_v[i] != 0 && (vpn >> sh) == (m_vpn[i] >> sh) && (m_g[i] != 0 || m_asn[i] == asn)) begin
            cnt++;
            if (first < 0) first = i;
         end
      end
      if (first >= 0) begin
         blk = 1 << (3 * m_sz[first]);
         exp_pa = ((m_pfn[first] / blk) * blk + (vpn % blk)) * 8192 + off;
         exp_prot = m_prot[first];
      end
      lk_va = VA_W'(vpn * 8192 + off);
      lk_asn = ASN_W'(asn);
      #1;
      if (first < 0) begin
         check(!lk_hit && !lk_multi, req, $sformatf("miss vpn=%0h asn=%0d hit/multi", vpn, asn),
               {lk_hit, lk_multi}, 0);
      end else begin
         check(lk_hit && lk_multi == (cnt > 1) && lk_pa == PA_W'(exp_pa) && lk_prot == PROT_W'(exp_prot),
               req, $sformatf("hit vpn=%0h asn=%0d multi=%0d prot=%0h pa", vpn, asn, lk_multi, lk_prot),
               lk_pa, exp_pa);
      end
   endtask

   task automatic sweep(input string req, input int asn);
      for (int v = 0; v < NPAGES; v++) lookup(req, v, asn);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog run did not finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_v[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_sz[i] = 0;
         m_asn[i] = 0; m_g[i] = 0; m_prot[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 R11: empty after reset
      sweep("R1 R11", 5);

      // pointer starts at slot 0: mixed sizes, address spaces and global slots
      op(1, 0, 0,   10, 100,    0, 5, 0, 1);
      op(1, 0, 0,   64, 'h1238, 1, 5, 0, 2);
      op(1, 0, 0,  512, 'h0A40, 2, 9, 0, 3);
      op(1, 0, 0, 1024, 'h1E00, 3, 0, 1, 4);
      op(1, 0, 0,   20, 7,      0, 9, 0, 5);
      op(1, 0, 0,   20, 8,      0, 5, 0, 6);
      op(1, 0, 0,  200, 'h155,  1, 0, 1, 7);
      op(1, 0, 0, 1600, 'h0BCD, 3, 5, 0, 8);
      // R2 R3 R4 R5 R11: full page sweep under three address spaces
      sweep("R2 R3 R4 R5 R11", 5);
      sweep("R2 R3 R4 R5 R11", 9);
      sweep("R4 R11", 3);

      // R6: ninth fill wraps to slot 0
      op(1, 0, 0, 30, 55, 0, 3, 0, 9);
      lookup("R6", 10, 5);
      lookup("R6", 30, 3);
      sweep("R6", 5);

      // R8: local invalidate keeps only global slots
      op(0, 0, 1, 0, 0, 0, 0, 0, 0);
      sweep("R8", 5);
      sweep("R8", 3);

      // R7: invalidate everything
      op(0, 1, 0, 0, 0, 0, 0, 0, 0);
      sweep("R7", 0);

      // R9: overlapping slots 1 and 2, lower one wins
      op(1, 0, 0, 64, 'h0800, 1, 5, 0, 10);
      op(1, 0, 0, 66, 'h0333, 0, 5, 0, 11);
      lookup("R9", 66, 5);
      check(lk_multi == 1'b1, "R9", "multi flag on overlap", lk_multi, 1);
      check(lk_prot == 4'd10, "R9", "lowest slot prot", lk_prot, 10);
      check(lk_pa == PA_W'((('h0800 + 2) * 8192) + (66 * 97 + 55) % 8192), "R9", "lowest slot pa",
            lk_pa, (('h0800 + 2) * 8192) + (66 * 97 + 55) % 8192);
      sweep("R9", 5);

      // R10: fill together with invalidate-all keeps the new slot
      op(1, 1, 0, 300, 'h0777, 0, 5, 0, 12);
      lookup("R10", 300, 5);
      check(lk_hit == 1'b1, "R10", "fresh fill survives invalidate", lk_hit, 1);
      lookup("R10", 64, 5);
      check(lk_hit == 1'b0, "R10", "older slot cleared", lk_hit, 0);
      op(1, 0, 1, 400, 'h0100, 0, 6, 0, 13);
      sweep("R10", 5);
      sweep("R10", 6);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule